// File: doc/BRIEF.md
# GF(2^128) Montgomery multiplier

This block multiplies two 128-bit elements of the binary field defined by x^128 + x^127 + x^126 + x^121 + 1 and returns a·b·x^-128 reduced by that polynomial. Element bits are little-endian: bit i is the coefficient of x^i. The full carry-less product is built from four 64×64 partial products: low×low, both cross terms and high×high. It is then folded in two steps, each a 64×64 carry-less multiply by the constant 0xC200000000000000. When both operands are in Montgomery form (the element times x^128), the result is the Montgomery form of their product.

The unit is sequential. One start pulse captures the operands and the mode. A parameter sets how many 64×64 multipliers work in parallel: 1, 2 or 4. The four partial products take 4/LANES cycles. The two reduction steps always take one cycle each, because the second step needs the result of the first, and both use lane 0. done pulses for one cycle, and the outputs hold until the next accepted start. The raw 256-bit product can be returned without reduction. A caller can also load any 256-bit value and reduce it alone, so several raw products can be XOR-summed and reduced once.

Top module: `gfm_mont_mul`

## Requirements
- R1: With mode_i = 0 (full), and with the unused code mode_i = 3, which acts as full, res_o equals a_i·b_i·x^-128 mod x^128+x^127+x^126+x^121+1, where bit i of a vector is the coefficient of x^i.
- R2: Multiplying any a by 128'hC2000000000000000000000000000001 (x^128 mod the polynomial, the Montgomery form of 1) returns a, in either operand order.
- R3: A full multiply with a zero operand gives res_o = 0.
- R4: With mode_i = 1 (raw), prod_o equals the unreduced 256-bit carry-less product of a_i and b_i.
- R5: With mode_i = 2 (reduce), res_o equals wide_i·x^-128 mod the polynomial. The reduced XOR of two raw products therefore equals the XOR of the two full results.
- R6: done_o rises exactly 4/LANES+2 (full), 4/LANES (raw) or 2 (reduce) clock edges after the edge that accepts start_i, and stays high for one cycle only.
- R7: busy_o is high from the accepting edge until done_o rises. A start_i pulse while busy_o is high has no effect on the result and starts no new operation.
- R8: res_o and prod_o hold their values between done_o and the next accepted start, whatever the other inputs do.
- R9: During and right after reset, busy_o, done_o, res_o and prod_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an operation; sampled only when idle |
| mode_i | input | 2 | 0 full, 1 raw product, 2 reduce wide_i, 3 as full |
| a_i | input | 128 | First operand |
| b_i | input | 128 | Second operand |
| wide_i | input | 256 | Value to reduce in reduce mode |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | 128 | Reduced result (full and reduce modes) |
| prod_o | output | 256 | Unreduced product (raw mode) |

## Verification
The bench drives two instances from the same inputs. One has LANES = 1, where all four partial products pass through a single shared multiplier over four cycles, with the operand-half selection and the shift of each product into the accumulator. The other has LANES = 4, where all products land in one cycle and reduction follows at once, so the latency and busy timing differ. Both instances must match a bit-serial multiply followed by 128 divisions by x, and each must meet its own cycle count.

// File: rtl/gfm_pkg.sv
`timescale 1ns/1ps
package gfm_pkg;
  localparam int FW = 128;
  localparam int HW = FW / 2;
  localparam int PW = 2 * FW;
  localparam logic [HW-1:0] RED_K = 64'hC200_0000_0000_0000;

  localparam logic [1:0] MODE_FULL = 2'd0;
  localparam logic [1:0] MODE_RAW  = 2'd1;
  localparam logic [1:0] MODE_RED  = 2'd2;

  typedef enum logic [1:0] {PH_IDLE, PH_MUL, PH_RED1, PH_RED2} phase_e;

  function automatic logic [FW-1:0] swap_halves(input logic [FW-1:0] v);
    return {v[HW-1:0], v[FW-1:HW]};
  endfunction
endpackage

// File: rtl/gfm_clmul.sv
`timescale 1ns/1ps
module gfm_clmul #(
  parameter int W = 64
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  always_comb begin
    p_o = '0;
    for (int i = 0; i < W; i++)
      if (b_i[i]) p_o ^= {{W{1'b0}}, a_i} << i;
  end
endmodule

// File: rtl/gfm_sched.sv
`timescale 1ns/1ps
module gfm_sched import gfm_pkg::*; #(
  parameter int MUL_CYC = 4,
  parameter int STEP_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  output logic              load_o,
  output phase_e            phase_o,
  output logic [STEP_W-1:0] step_o,
  output logic [1:0]        mode_o,
  output logic              busy_o,
  output logic              done_o
);
  phase_e            ph_q;
  logic [STEP_W-1:0] step_q;
  logic [1:0]        mode_q;
  logic              done_q;

  assign load_o = (ph_q == PH_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      step_q <= '0;
      mode_q <= MODE_FULL;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph_q)
        PH_IDLE: if (start_i) begin
          mode_q <= mode_i;
          step_q <= '0;
          ph_q   <= (mode_i == MODE_RED) ? PH_RED1 : PH_MUL;
        end
        PH_MUL: begin
          if (step_q == STEP_W'(MUL_CYC - 1)) begin
            if (mode_q == MODE_RAW) begin
              ph_q   <= PH_IDLE;
              done_q <= 1'b1;
            end else begin
              ph_q <= PH_RED1;
            end
          end
          step_q <= step_q + 1'b1;
        end
        PH_RED1: ph_q <= PH_RED2;
        PH_RED2: begin
          ph_q   <= PH_IDLE;
          done_q <= 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = ph_q;
  assign step_o  = step_q;
  assign mode_o  = mode_q;
  assign busy_o  = (ph_q != PH_IDLE);
  assign done_o  = done_q;

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7: busy has fallen by the time done is seen
  p_busy_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/gfm_mont_mul.sv
`timescale 1ns/1ps
module gfm_mont_mul import gfm_pkg::*; #(
  parameter int LANES = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [FW-1:0] a_i,
  input  logic [FW-1:0] b_i,
  input  logic [PW-1:0] wide_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [FW-1:0] res_o,
  output logic [PW-1:0] prod_o
);
  localparam int MUL_CYC = 4 / LANES;
  localparam int STEP_W  = 3;

  logic [FW-1:0]     a_q, b_q;
  logic [PW-1:0]     acc_q;
  logic [3:0]        lat_q;
  logic              load;
  phase_e            phase;
  logic [STEP_W-1:0] step;
  logic [1:0]        mode_q;
  logic [FW-1:0]     prod [LANES];
  logic [1:0]        sh   [LANES];
  logic [PW-1:0]     mul_sum;
  logic [FW-1:0]     pl_n;

  gfm_sched #(.MUL_CYC(MUL_CYC), .STEP_W(STEP_W)) i_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mode_i  (mode_i),
    .load_o  (load),
    .phase_o (phase),
    .step_o  (step),
    .mode_o  (mode_q),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [2:0]    pidx;
    logic [HW-1:0] x, y;
    always_comb begin
      pidx  = 3'(int'(step) * LANES + l);
      // pidx[1] picks the a half, pidx[0] the b half
      x     = pidx[1] ? a_q[FW-1:HW] : a_q[HW-1:0];
      y     = pidx[0] ? b_q[FW-1:HW] : b_q[HW-1:0];
      sh[l] = {1'b0, pidx[1]} + {1'b0, pidx[0]};
      if (l == 0 && phase == PH_RED1) begin
        x = acc_q[HW-1:0];
        y = RED_K;
      end else if (l == 0 && phase == PH_RED2) begin
        x = acc_q[FW-1:HW];
        y = RED_K;
      end
    end
    gfm_clmul #(.W(HW)) i_clmul (.a_i(x), .b_i(y), .p_o(prod[l]));
  end

  always_comb begin
    mul_sum = '0;
    for (int l = 0; l < LANES; l++)
      mul_sum ^= {{FW{1'b0}}, prod[l]} << (HW * sh[l]);
  end

  assign pl_n = acc_q[FW-1:0] ^ swap_halves(prod[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
      lat_q <= '0;
    end else if (load) begin
      a_q   <= a_i;
      b_q   <= b_i;
      acc_q <= (mode_i == MODE_RED) ? wide_i : '0;
      lat_q <= '0;
    end else begin
      if (busy_o) lat_q <= lat_q + 4'd1;
      case (phase)
        PH_MUL:  acc_q <= acc_q ^ mul_sum;
        PH_RED1: acc_q <= {acc_q[PW-1:FW] ^ pl_n, pl_n};
        PH_RED2: acc_q[PW-1:FW] <= acc_q[PW-1:FW] ^ prod[0];
        default: ;
      endcase
    end
  end

  assign res_o  = acc_q[PW-1:FW];
  assign prod_o = acc_q;

  // R6: done arrives after the mode's cycle count
  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == ((mode_q == MODE_RED) ? 4'd2 :
                         (mode_q == MODE_RAW) ? 4'(MUL_CYC) : 4'(MUL_CYC + 2)));
  // R7: captured operands are frozen while busy
  p_opnd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(a_q) && $stable(b_q));
  // R8: outputs held while idle without start
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(prod_o));
  // R3: zero operand reduces to zero
  p_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q != MODE_RAW && mode_q != MODE_RED && (a_q == '0 || b_q == '0))
      |-> res_o == '0);
endmodule

// File: tb/test_gfm_mont_mul.sv
`timescale 1ns/1ps
module test_gfm_mont_mul;
  localparam logic [127:0] MONT_ONE = 128'hC2000000000000000000000000000001;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [127:0] a = '0, b = '0;
  logic [255:0] w = '0;
  logic         busy1, done1, busy4, done4;
  logic [127:0] res1, res4;
  logic [255:0] prod1, prod4;

  int n_cmp = 0, n_bad = 0;
  logic [127:0] r1, r4;
  logic [255:0] q1, q4;
  int l1, l4;
  bit dbl;

  always #4 clk = ~clk;

  gfm_mont_mul #(.LANES(1)) i_gfm_mont_mul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .a_i(a), .b_i(b),
    .wide_i(w), .busy_o(busy1), .done_o(done1), .res_o(res1), .prod_o(prod1));

  gfm_mont_mul #(.LANES(4)) i_gfm_mont_mul_quad (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .a_i(a), .b_i(b),
    .wide_i(w), .busy_o(busy4), .done_o(done4), .res_o(res4), .prod_o(prod4));

  function automatic logic [255:0] clmul_ref(input logic [127:0] x, input logic [127:0] y);
    logic [255:0] r = '0;
    for (int i = 0; i < 128; i++) if (y[i]) r ^= {128'b0, x} << i;
    return r;
  endfunction

  function automatic logic [127:0] divx_ref(input logic [255:0] v);
    logic [255:0] pm = '0;
    pm[128] = 1'b1; pm[127] = 1'b1; pm[126] = 1'b1; pm[121] = 1'b1; pm[0] = 1'b1;
    for (int i = 0; i < 128; i++) begin
      if (v[0]) v ^= pm;
      v >>= 1;
    end
    return v[127:0];
  endfunction

  function automatic logic [127:0] mont_ref(input logic [127:0] x, input logic [127:0] y);
    return divx_ref(clmul_ref(x, y));
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic int lat_exp(input int lanes, input logic [1:0] m);
    if (m == 2'd2) return 2;
    if (m == 2'd1) return 4 / lanes;
    return 4 / lanes + 2;
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic kick(input logic [1:0] m, input logic [127:0] x, input logic [127:0] y,
                      input logic [255:0] z);
    @(negedge clk);
    mode = m; a = x; b = y; w = z; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic collect(input int n0);
    int n = n0;
    bit g1 = 0, g4 = 0;
    dbl = 0; l1 = -1; l4 = -1;
    while (!(g1 && g4) && n < 40) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (done1) begin
        if (g1) dbl = 1;
        else begin g1 = 1; l1 = n; r1 = res1; q1 = prod1; end
      end
      if (done4) begin
        if (g4) dbl = 1;
        else begin g4 = 1; l4 = n; r4 = res4; q4 = prod4; end
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (done1 || done4) dbl = 1;
  endtask

  task automatic run(input logic [1:0] m, input logic [127:0] x, input logic [127:0] y,
                     input logic [255:0] z);
    kick(m, x, y, z);
    collect(0);
    chk("R6 latency lanes1", 256'(l1), 256'(lat_exp(1, m)));
    chk("R6 latency lanes4", 256'(l4), 256'(lat_exp(4, m)));
    chk("R6 done single pulse", 256'(dbl), 256'(0));
  endtask

  task automatic t_reset();
    chk("R9 reset busy/done", {252'b0, busy1, done1, busy4, done4}, 256'b0);
    chk("R9 reset res", {res1, res4}, 256'b0);
    chk("R9 reset prod lanes1", prod1, 256'b0);
    chk("R9 reset prod lanes4", prod4, 256'b0);
  endtask

  task automatic t_zero();
    logic [127:0] x = rnd128();
    run(2'd0, 128'b0, x, '0);
    chk("R3 zero a lanes1", 256'(r1), 256'b0);
    chk("R3 zero a lanes4", 256'(r4), 256'b0);
    run(2'd0, x, 128'b0, '0);
    chk("R3 zero b lanes1", 256'(r1), 256'b0);
    chk("R3 zero b lanes4", 256'(r4), 256'b0);
  endtask

  task automatic t_identity();
    logic [127:0] x = rnd128();
    run(2'd0, x, MONT_ONE, '0);
    chk("R2 a*one lanes1", 256'(r1), 256'(x));
    chk("R2 a*one lanes4", 256'(r4), 256'(x));
    run(2'd0, MONT_ONE, x, '0);
    chk("R2 one*b lanes1", 256'(r1), 256'(x));
    chk("R2 one*b lanes4", 256'(r4), 256'(x));
  endtask

  task automatic t_random();
    for (int k = 0; k < 8; k++) begin
      logic [127:0] x = rnd128(), y = rnd128();
      if (k == 0) begin x = '1; y = '1; end
      if (k == 1) begin x = 128'h1; y = 128'h8000_0000_0000_0000_0000_0000_0000_0000; end
      run(2'd0, x, y, '0);
      chk("R1 full lanes1", 256'(r1), 256'(mont_ref(x, y)));
      chk("R1 full lanes4", 256'(r4), 256'(mont_ref(x, y)));
    end
    begin
      logic [127:0] x = rnd128(), y = rnd128();
      run(2'd3, x, y, '0);
      chk("R1 mode3 lanes1", 256'(r1), 256'(mont_ref(x, y)));
      chk("R1 mode3 lanes4", 256'(r4), 256'(mont_ref(x, y)));
    end
  endtask

  task automatic t_raw();
    for (int k = 0; k < 3; k++) begin
      logic [127:0] x = rnd128(), y = rnd128();
      run(2'd1, x, y, '0);
      chk("R4 raw lanes1", q1, clmul_ref(x, y));
      chk("R4 raw lanes4", q4, clmul_ref(x, y));
    end
  endtask

  task automatic t_reduce();
    logic [127:0] x = rnd128(), y = rnd128(), u = rnd128(), v = rnd128();
    logic [255:0] z = {rnd128(), rnd128()};
    logic [255:0] s;
    run(2'd2, rnd128(), rnd128(), z);
    chk("R5 reduce lanes1", 256'(r1), 256'(divx_ref(z)));
    chk("R5 reduce lanes4", 256'(r4), 256'(divx_ref(z)));
    run(2'd1, x, y, '0);
    s = q1;
    run(2'd1, u, v, '0);
    s ^= q1;
    run(2'd2, '0, '0, s);
    chk("R5 summed reduce lanes1", 256'(r1), 256'(mont_ref(x, y) ^ mont_ref(u, v)));
    chk("R5 summed reduce lanes4", 256'(r4), 256'(mont_ref(x, y) ^ mont_ref(u, v)));
  endtask

  task automatic t_busy();
    logic [127:0] x = rnd128(), y = rnd128();
    kick(2'd0, x, y, '0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 busy while running", {254'b0, busy1, busy4}, 256'b11);
    start = 1'b1; mode = 2'd1; a = ~x; b = ~y;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    collect(2);
    chk("R7 ignored start lanes1", 256'(r1), 256'(mont_ref(x, y)));
    chk("R7 ignored start lanes4", 256'(r4), 256'(mont_ref(x, y)));
    chk("R7 latency unchanged lanes1", 256'(l1), 256'(lat_exp(1, 2'd0)));
    chk("R7 no restart", {254'b0, busy1, busy4}, 256'b0);
  endtask

  task automatic t_hold();
    logic [127:0] x = rnd128(), y = rnd128();
    run(2'd0, x, y, '0);
    a = rnd128(); b = rnd128(); w = {rnd128(), rnd128()}; mode = 2'd2;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R8 hold res lanes1", 256'(res1), 256'(r1));
    chk("R8 hold prod lanes1", prod1, q1);
    chk("R8 hold res lanes4", 256'(res4), 256'(r4));
    chk("R8 hold prod lanes4", prod4, q4);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_identity();
    t_random();
    t_raw();
    t_reduce();
    t_busy();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule